// File: doc/BRIEF.md
# Timer Compare/Capture Event Flags

This block keeps the event status of a three-channel free-running 16-bit timer. Each channel has a counter and two general registers, A and B. A per-register mode bit makes the register either a compare target or a capture register. In compare mode the register's event flag sets when the channel counter equals the register. In capture mode the flag sets when a rising edge on the register's capture input copies the counter into the register. Each flag has an enable bit, and each flag/enable pair drives its own interrupt request line.

Software reaches the block through an 8-bit register bus with an address, a read strobe and a write strobe. Read data is registered and appears the cycle after the read strobe. Flags are protected against blind clearing. A flag clears only when a status read has returned it as 1 and the next write to that status register puts 0 in its bit. Writing 1 to a flag never sets it. A synchronous standby input returns both status registers to their initial value.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset, and in the cycle after standby is high, both status registers read 0x88 and all interrupt lines are 0. Standby also drops every pending read-arm.
- R2: Status register A is at address 0x00 and status register B is at 0x01. In each, bits 7 and 3 read 1, bits 6..4 are the enables for channels 2..0, and bits 2..0 are the flags for channels 2..0.
- R3: In compare mode (mode bit 0), a flag sets on the clock edge at which the channel counter equals its general register.
- R4: The mode register is at 0x02, with bits 2..0 for the A registers of channels 2..0, bits 6..4 for the B registers, and 1 meaning capture. In capture mode, a rising capture input is synchronised through two flops and yields one pulse. On the third clock edge after the input rises, the register takes the counter value and the flag sets. A held high level or a falling edge causes no further capture.
- R5: Counters increment every cycle and wrap from 0xFFFF to 0x0000. A byte write replaces that byte at the counter high address 0x04+2*ch or the low address 0x05+2*ch, and the other byte holds for that cycle.
- R6: A write of 0 to a flag clears it only if a read of that status register returned the flag as 1 after the previous write to the register. A read that returned the flag as 0 does not arm it.
- R7: Any write to a status register disarms all its flags. A flag bit written as 1 stays unchanged, and software can never set a flag.
- R8: When a set event and a clearing write fall on the same edge, the flag stays 1.
- R9: Enable bits are freely writable. Each interrupt line is high exactly while its flag and its enable are both 1.
- R10: For channel ch, the general registers are byte-addressed at 0x0A+4*ch (A high), +1 (A low), +2 (B high) and +3 (B low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Standby entry, re-initialises the status registers |
| addr | input | AW | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cap_a | input | 3 | Asynchronous capture inputs for the A registers |
| cap_b | input | 3 | Asynchronous capture inputs for the B registers |
| irq_a | output | 3 | Interrupt requests for the A flags |
| irq_b | output | 3 | Interrupt requests for the B flags |

## Verification
The bench first sends a clearing write with no arming read, then an arming read followed by a write of 1 and then 0. A design that cleared on any 0 write, or kept its arm across writes, would lose the flag there. It also lines a compare match up with the clearing write on the same edge. A design where the clear wins would drop the interrupt. A captured value is checked to the exact count, two counts past the value written before the input rose, so a wrong synchroniser depth shows up. A held capture input must not retrigger, a match that needs the counter to wrap past 0xFFFF must fire, and a disabled enable must gate the interrupt while the flag still reads back.

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [2:0]    cap_a,
  input  logic [2:0]    cap_b,
  output logic [2:0]    irq_a,
  output logic [2:0]    irq_b
);
  localparam int NCH    = 3;
  localparam int A_STA  = 0;
  localparam int A_STB  = 1;
  localparam int A_MODE = 2;
  localparam int A_CNT  = 4;
  localparam int A_GR   = 10;

  logic [15:0] cnt [NCH];
  logic [15:0] gra [NCH];
  logic [15:0] grb [NCH];
  logic [2:0]  sa1, sa2, sa3, sb1, sb2, sb3;
  logic [2:0]  cm_a, cm_b;
  logic [2:0]  fl_a, fl_b, ie_a, ie_b, arm_a, arm_b;
  logic [2:0]  set_a, set_b;
  logic [7:0]  rd_mux;

  wire [2:0] pls_a  = sa2 & ~sa3;
  wire [2:0] pls_b  = sb2 & ~sb3;
  wire       wr_sta = wr && addr == AW'(A_STA);
  wire       wr_stb = wr && addr == AW'(A_STB);
  wire       rd_sta = rd && addr == AW'(A_STA);
  wire       rd_stb = rd && addr == AW'(A_STB);

  assign irq_a = fl_a & ie_a;
  assign irq_b = fl_b & ie_b;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      set_a[i] = cm_a[i] ? pls_a[i] : (cnt[i] == gra[i]);
      set_b[i] = cm_b[i] ? pls_b[i] : (cnt[i] == grb[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sa1, sa2, sa3} <= '0;
      {sb1, sb2, sb3} <= '0;
    end else begin
      sa1 <= cap_a; sa2 <= sa1; sa3 <= sa2;
      sb1 <= cap_b; sb2 <= sb1; sb3 <= sb2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_a <= '0;
      cm_b <= '0;
    end else if (wr && addr == AW'(A_MODE)) begin
      cm_a <= wdata[2:0];
      cm_b <= wdata[6:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        cnt[i] <= '0;
        gra[i] <= '1;
        grb[i] <= '1;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        cnt[i] <= cnt[i] + 16'd1;
        if (wr && addr == AW'(A_CNT + 2*i))     cnt[i] <= {wdata, cnt[i][7:0]};
        if (wr && addr == AW'(A_CNT + 2*i + 1)) cnt[i] <= {cnt[i][15:8], wdata};
        if (wr && addr == AW'(A_GR + 4*i))      gra[i][15:8] <= wdata;
        if (wr && addr == AW'(A_GR + 4*i + 1))  gra[i][7:0]  <= wdata;
        if (wr && addr == AW'(A_GR + 4*i + 2))  grb[i][15:8] <= wdata;
        if (wr && addr == AW'(A_GR + 4*i + 3))  grb[i][7:0]  <= wdata;
        if (cm_a[i] && pls_a[i]) gra[i] <= cnt[i];
        if (cm_b[i] && pls_b[i]) grb[i] <= cnt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {fl_a, ie_a, arm_a} <= '0;
      {fl_b, ie_b, arm_b} <= '0;
    end else if (stby) begin
      {fl_a, ie_a, arm_a} <= '0;
      {fl_b, ie_b, arm_b} <= '0;
    end else begin
      if (wr_sta) ie_a <= wdata[6:4];
      if (wr_stb) ie_b <= wdata[6:4];
      fl_a  <= (fl_a & ~(wr_sta ? (arm_a & ~wdata[2:0]) : 3'b0)) | set_a;
      fl_b  <= (fl_b & ~(wr_stb ? (arm_b & ~wdata[2:0]) : 3'b0)) | set_b;
      arm_a <= wr_sta ? 3'b0 : (rd_sta ? (arm_a | fl_a) : arm_a);
      arm_b <= wr_stb ? 3'b0 : (rd_stb ? (arm_b | fl_b) : arm_b);
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (addr == AW'(A_STA))  rd_mux = {1'b1, ie_a, 1'b1, fl_a};
    if (addr == AW'(A_STB))  rd_mux = {1'b1, ie_b, 1'b1, fl_b};
    if (addr == AW'(A_MODE)) rd_mux = {1'b0, cm_b, 1'b0, cm_a};
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(A_CNT + 2*i))     rd_mux = cnt[i][15:8];
      if (addr == AW'(A_CNT + 2*i + 1)) rd_mux = cnt[i][7:0];
      if (addr == AW'(A_GR + 4*i))      rd_mux = gra[i][15:8];
      if (addr == AW'(A_GR + 4*i + 1))  rd_mux = gra[i][7:0];
      if (addr == AW'(A_GR + 4*i + 2))  rd_mux = grb[i][15:8];
      if (addr == AW'(A_GR + 4*i + 3))  rd_mux = grb[i][7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (rd) rdata <= rd_mux;
  end

  AST_STBY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (fl_a == 3'b0 && fl_b == 3'b0 && irq_a == 3'b0 && irq_b == 3'b0)); // R1
  AST_UNARMED_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |=> (($past(fl_a & ~arm_a) & ~fl_a) == 3'b0)); // R6
  AST_UNARMED_B_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |=> (($past(fl_b & ~arm_b) & ~fl_b) == 3'b0)); // R6
  AST_SET_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |=> (($past(set_a) & ~fl_a) == 3'b0)); // R8
  AST_SET_WINS_B: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |=> (($past(set_b) & ~fl_b) == 3'b0)); // R8
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((fl_a & ~$past(fl_a) & ~$past(set_a)) | (fl_b & ~$past(fl_b) & ~$past(set_b))) == 3'b0)); // R7
  AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pls_a | pls_b)) |=> (((pls_a | pls_b) & $past(pls_a | pls_b)) == 3'b0)); // R4
endmodule

// File: tb/tmr_evt_flags_bench.sv
`timescale 1ns/1ps
module tmr_evt_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stby = 1'b0;
  logic [4:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] cap_a = '0;
  logic [2:0] cap_b = '0;
  logic [2:0] irq_a, irq_b;

  int tests = 0;
  int fails = 0;
  logic pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  tmr_evt_flags #(.AW(5)) u_tmr_evt_flags (
    .clk(clk), .rst_n(rst_n), .stby(stby), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .cap_a(cap_a), .cap_b(cap_b),
    .irq_a(irq_a), .irq_b(irq_b));

  always @(posedge clk) pend <= rd;

  always @(negedge clk) begin
    if (pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s read: got %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic chk(input logic [2:0] got, input logic [2:0] e, input string t);
    tests++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s irq: got %03b expected %03b", t, got, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rd_exp(5'h00, 8'h88, "R1 R2 status A reset");
    rd_exp(5'h01, 8'h88, "R1 R2 status B reset");
    chk(irq_a, 3'b000, "R1 irq_a reset");
    chk(irq_b, 3'b000, "R1 irq_b reset");

    wr_reg(5'h01, 8'h77);
    rd_exp(5'h01, 8'hF8, "R7 R9 flags not set by software, enables written");
    chk(irq_b, 3'b000, "R7 no irq from write of 1");

    wr_reg(5'h0C, 8'h01); wr_reg(5'h0D, 8'h00);
    wr_reg(5'h04, 8'h00); wr_reg(5'h05, 8'hF0);
    idle(40);
    chk(irq_b, 3'b001, "R3 R9 compare match B0");

    wr_reg(5'h01, 8'h70);
    chk(irq_b, 3'b001, "R6 clear without arming read");
    rd_exp(5'h01, 8'hF9, "R3 flag B0 reads 1");
    wr_reg(5'h01, 8'h71);
    wr_reg(5'h01, 8'h70);
    chk(irq_b, 3'b001, "R7 write disarms");
    rd_exp(5'h01, 8'hF9, "R7 flag kept");
    wr_reg(5'h01, 8'h70);
    chk(irq_b, 3'b000, "R6 armed clear");
    rd_exp(5'h01, 8'hF8, "R6 flag cleared");

    wr_reg(5'h04, 8'h00); wr_reg(5'h05, 8'hF0);
    idle(40);
    rd_exp(5'h01, 8'hF9, "R3 second match");
    wr_reg(5'h04, 8'h00);
    wr_reg(5'h05, 8'hFF);
    wr_reg(5'h02, 8'h00);
    wr_reg(5'h01, 8'h70);
    chk(irq_b, 3'b001, "R8 set wins over clear");
    rd_exp(5'h01, 8'hF9, "R8 flag still 1");
    wr_reg(5'h01, 8'h70);
    rd_exp(5'h01, 8'hF8, "R6 cleared after set-wins");

    wr_reg(5'h02, 8'h20);
    wr_reg(5'h06, 8'h12);
    wr_reg(5'h07, 8'h34);
    cap_b = 3'b010;
    idle(6);
    chk(irq_b, 3'b010, "R4 capture flag B1");
    rd_exp(5'h10, 8'h12, "R4 R10 captured high byte");
    rd_exp(5'h11, 8'h36, "R4 R10 captured low byte");
    rd_exp(5'h01, 8'hFA, "R4 status after capture");
    rd_exp(5'h02, 8'h20, "R4 mode readback");
    wr_reg(5'h01, 8'h70);
    idle(10);
    chk(irq_b, 3'b000, "R4 held level no retrigger");
    cap_b = 3'b000;
    idle(5);
    chk(irq_b, 3'b000, "R4 falling edge no capture");

    wr_reg(5'h00, 8'h20);
    wr_reg(5'h12, 8'h00); wr_reg(5'h13, 8'h50);
    wr_reg(5'h08, 8'h00); wr_reg(5'h09, 8'h40);
    idle(30);
    chk(irq_a, 3'b000, "R9 gated by enable");
    rd_exp(5'h00, 8'hAC, "R2 R3 status A flag2");
    wr_reg(5'h00, 8'h64);
    chk(irq_a, 3'b100, "R9 enable raises irq");
    chk(irq_b, 3'b000, "R2 B side untouched");
    rd_exp(5'h13, 8'h50, "R10 GA2 low readback");

    wr_reg(5'h0A, 8'h00); wr_reg(5'h0B, 8'h01);
    wr_reg(5'h00, 8'h74);
    wr_reg(5'h04, 8'hFF); wr_reg(5'h05, 8'hFE);
    idle(10);
    chk(irq_a, 3'b101, "R5 match after wrap");

    stby = 1'b1;
    idle(1);
    stby = 1'b0;
    chk(irq_a, 3'b000, "R1 standby irq_a");
    rd_exp(5'h00, 8'h88, "R1 standby status A");
    rd_exp(5'h01, 8'h88, "R1 standby status B");

    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule